// File: doc/BRIEF.md
# Cascadable Framed Serial Deserializer

This block turns a one-bit serial stream into a parallel word of up to ten bits. It runs on a fast bit clock at M times the word rate and watches a separate slow frame clock at the word rate to decide when a complete word sits in its shift register. The ratio M is a configuration input from 4 to 40. The word is left-aligned on the parallel outputs: the first bit received lands on the top output.

Words longer than ten bits are handled by chaining units. The unit that takes the line data is marked as the lead. It keeps only the last bits of each word and passes older bits on through its cascade output to the next unit. Every further unit keeps a full ten bits. An enable input and the active-low reset force the parallel outputs to zero. Captured words are held until the next capture.

Top module: `cascade_deser`

## Requirements
- R1: Serial data is sampled on every falling edge of `clk_i` into a ten-stage shift register, and words are sent most-significant bit first.
- R2: A rising edge of `frame_i` is detected at a falling edge of `clk_i`. The parallel word is loaded on the second rising edge of `clk_i` after that falling edge. The word is aligned when `frame_i` is first seen high at the falling edge that samples the word's second-to-last bit.
- R3: For M from 4 to 10, a lead unit shows word bit M-1 on `par_o[9]` and word bit 0 on `par_o[10-M]`.
- R4: On the lead unit, the outputs below index 10-L are 0, where L is the lead segment length (R5).
- R5: The lead segment length L is M when M is 10 or less. Above 10 it is M mod 10, or 10 when that remainder is 0. Non-lead units use a length of 10. `casc_o` carries the bit that leaves stage L-1, so the next unit samples it on the same falling edge.
- R6: For M above 10, the lead unit shows word bits L-1..0 from `par_o[9]` down. Chained unit k (k = 1, 2, ...) shows word bits L+10k-1 down to L+10(k-1) on `par_o[9:0]`.
- R7: While `en_i` is low, `par_o` is all zero. Capture goes on while the block is disabled, and raising `en_i` shows the word captured last.
- R8: While `rst_ni` is low, and after reset until the first capture, `par_o` is all zero.
- R9: `par_o` holds its value between captures.
- R10: Each detected rising edge of the frame clock causes exactly one load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; shifts on the falling edge, loads on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame clock at the word rate |
| ser_i | input | 1 | Serial data: line data for the lead unit, previous unit's `casc_o` otherwise |
| en_i | input | 1 | Output enable, active high |
| lead_i | input | 1 | High on the unit that receives the line data |
| m_i | input | 6 | Multiplexing ratio M, 4 to 40 |
| par_o | output | 10 | Parallel word, left-aligned |
| casc_o | output | 1 | Cascade serial output to the next unit |

## Verification
On every cycle, the assertions check that the parallel outputs hold steady between loads and that load strobes never come back to back. After each load they also check that the top output bit matches the bit at the cascade tap and that the unused low outputs of a lead unit are zero. Only the bench scenarios can show the end-to-end word mapping. It chains four units over several ratios, checks the exact capture cycle against the frame clock, and checks that a word captured while the block was disabled appears once the enable goes high.

// File: rtl/dsr_pkg.sv
`timescale 1ns/1ps
package dsr_pkg;
  localparam int unsigned WORD_W = 10;
  localparam int unsigned M_MIN  = 4;
  localparam int unsigned M_MAX  = 40;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_ARMED
  } seq_state_e;

  // Active length of the shift register for one unit in the chain
  function automatic int unsigned calc_seg_len(input int unsigned m, input logic lead,
                                               input int unsigned w);
    int unsigned rem;
    if (!lead) return w;
    if (m < M_MIN) return M_MIN;
    if (m <= w) return m;
    rem = m % w;
    return (rem == 0) ? w : rem;
  endfunction
endpackage

// File: rtl/dsr_shift.sv
`timescale 1ns/1ps
module dsr_shift #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  input  logic [LEN_W-1:0]  seg_len_i,
  output logic [WORD_W-1:0] sr_o,
  output logic              casc_o
);
  logic [WORD_W-1:0] sr_q;
  logic              casc;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[WORD_W-2:0], ser_i};
  end

  // Cascade tap sits at the last active stage
  always_comb begin
    casc = 1'b0;
    for (int i = 0; i < WORD_W; i++) begin
      if (seg_len_i == LEN_W'(i + 1)) casc = sr_q[i];
    end
  end

  assign sr_o   = sr_q;
  assign casc_o = casc;
endmodule

// File: rtl/dsr_frame_seq.sv
`timescale 1ns/1ps
module dsr_frame_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  output logic load_o
);
  import dsr_pkg::*;

  logic       frame_q;
  logic       rise_q;
  seq_state_e state_q;
  seq_state_e state_d;

  // Frame edge is taken at the falling edge, next to the shift
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      frame_q <= frame_i;
      rise_q  <= frame_i & ~frame_q;
    end
  end

  // First rising edge after detection arms, second one loads
  always_comb begin
    state_d = SEQ_IDLE;
    if (state_q == SEQ_IDLE && rise_q) state_d = SEQ_ARMED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign load_o = (state_q == SEQ_ARMED);

  assert_load_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
endmodule

// File: rtl/dsr_outstage.sv
`timescale 1ns/1ps
module dsr_outstage #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              en_i,
  input  logic [LEN_W-1:0]  seg_len_i,
  input  logic [WORD_W-1:0] sr_i,
  output logic [WORD_W-1:0] par_o
);
  logic [WORD_W-1:0] aligned;
  logic [WORD_W-1:0] hold_q;

  // Left-align the active segment; stale upper stages fall off
  assign aligned = sr_i << (LEN_W'(WORD_W) - seg_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (load_i) hold_q <= aligned;
  end

  assign par_o = en_i ? hold_q : '0;

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> (!en_i || $stable(par_o)));
endmodule

// File: rtl/cascade_deser.sv
`timescale 1ns/1ps
module cascade_deser #(
  parameter int unsigned WORD_W = dsr_pkg::WORD_W,
  parameter int unsigned M_W    = $clog2(dsr_pkg::M_MAX + 1),
  localparam int unsigned LEN_W = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              ser_i,
  input  logic              en_i,
  input  logic              lead_i,
  input  logic [M_W-1:0]    m_i,
  output logic [WORD_W-1:0] par_o,
  output logic              casc_o
);
  logic [LEN_W-1:0]  seg_len;
  logic [WORD_W-1:0] sr;
  logic              load;
  logic [WORD_W-1:0] low_mask;

  always_comb begin
    seg_len  = LEN_W'(dsr_pkg::calc_seg_len(32'(m_i), lead_i, WORD_W));
    low_mask = (WORD_W'(1) << (LEN_W'(WORD_W) - seg_len)) - WORD_W'(1);
  end

  dsr_shift #(.WORD_W(WORD_W), .LEN_W(LEN_W)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ser_i     (ser_i),
    .seg_len_i (seg_len),
    .sr_o      (sr),
    .casc_o    (casc_o)
  );

  dsr_frame_seq i_frame_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (frame_i),
    .load_o  (load)
  );

  dsr_outstage #(.WORD_W(WORD_W), .LEN_W(LEN_W)) i_outstage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .en_i      (en_i),
    .seg_len_i (seg_len),
    .sr_i      (sr),
    .par_o     (par_o)
  );

  // Top output bit after a load is the bit sitting at the cascade tap
  assert_msb_from_tap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (!en_i || par_o[WORD_W-1] == $past(casc_o)));

  assert_low_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (!$stable(m_i) || !$stable(lead_i) || ((par_o & low_mask) == '0)));
endmodule

// File: tb/test_cascade_deser.sv
`timescale 1ns/1ps
module test_cascade_deser;
  localparam int CLK_PERIOD = 20;
  localparam int UNITS      = 4;
  localparam int W          = 10;

  typedef struct packed {
    logic [39:0]      word;
    logic [UNITS-1:0] used;
    logic [5:0]       m;
  } exp_t;

  logic         clk   = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame = 1'b0;
  logic         line  = 1'b0;
  logic         en    = 1'b1;
  logic [5:0]   m_cfg = 6'd4;
  logic [W-1:0] par  [UNITS];
  logic         casc [UNITS];
  logic         ser  [UNITS];

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   pending  = 1'b0;
  exp_t sb_q[$];
  event ev_load;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ser[0] = line;
  for (genvar k = 1; k < UNITS; k++) begin : g_chain
    assign ser[k] = casc[k-1];
  end

  for (genvar k = 0; k < UNITS; k++) begin : g_unit
    cascade_deser i_cascade_deser (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .frame_i (frame),
      .ser_i   (ser[k]),
      .en_i    (en),
      .lead_i  (k == 0),
      .m_i     (m_cfg),
      .par_o   (par[k]),
      .casc_o  (casc[k])
    );
  end

  function automatic int lead_len(int m);
    int r;
    if (m <= W) return m;
    r = m % W;
    return (r == 0) ? W : r;
  endfunction

  function automatic bit unit_used(int m, int k);
    if (k == 0) return 1'b1;
    return (lead_len(m) + W * (k - 1)) < m;
  endfunction

  function automatic logic [W-1:0] unit_exp(logic [39:0] w, int m, int k);
    int l0 = lead_len(m);
    int off;
    logic [W-1:0] v = '0;
    if (k == 0) begin
      for (int i = 0; i < l0; i++) v[W - l0 + i] = w[i];
    end else begin
      off = l0 + W * (k - 1);
      for (int i = 0; i < W; i++) v[i] = w[off + i];
    end
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic fire_pending();
    if (pending) begin
      pending = 1'b0;
      -> ev_load;
    end
  endtask

  // Driver: MSB first; frame high from the second-to-last bit
  task automatic send_frame(logic [39:0] w);
    exp_t e;
    int   m = int'(m_cfg);
    e.word = w;
    e.m    = m_cfg;
    for (int k = 0; k < UNITS; k++) e.used[k] = unit_used(m, k);
    sb_q.push_back(e);
    for (int j = 0; j < m; j++) begin
      @(posedge clk);
      #1;
      line  = w[m - 1 - j];
      frame = (j >= m - 2);
      if (j == 0) fire_pending();
    end
    pending = 1'b1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      line  = 1'b0;
      frame = 1'b0;
      if (i == 0) fire_pending();
    end
  endtask

  // Monitor: right after the load edge, then just before the next one
  initial begin
    forever begin
      exp_t         e;
      logic [W-1:0] ev;
      string        tag;
      @(ev_load);
      e = sb_q.pop_front();
      #5;
      for (int k = 0; k < UNITS; k++) begin
        if (e.used[k]) begin
          ev  = en ? unit_exp(e.word, int'(e.m), k) : '0;
          tag = (k == 0) ? ((e.m <= 6'd10) ? "R1 R2 R3 R7" : "R2 R6 R7")
                         : "R2 R5 R6 R7";
          check(par[k] == ev, tag, $sformatf("unit %0d M=%0d after load", k, e.m), par[k], ev);
        end
      end
      if (en) begin
        ev = '0;
        check((par[0] & ~(~10'd0 << (W - lead_len(int'(e.m))))) == '0, "R4",
              $sformatf("lead low outputs M=%0d", e.m), par[0], ev);
      end
      #((int'(e.m) - 1) * CLK_PERIOD + 6);
      for (int k = 0; k < UNITS; k++) begin
        if (e.used[k]) begin
          ev = en ? unit_exp(e.word, int'(e.m), k) : '0;
          check(par[k] == ev, "R9 R10", $sformatf("unit %0d M=%0d held before next load", k, e.m),
                par[k], ev);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int          m_list[6] = '{4, 7, 10, 13, 20, 40};
    logic [39:0] last_w;
    repeat (3) @(negedge clk);
    for (int k = 0; k < UNITS; k++) check(par[k] == '0, "R8", "during reset", par[k], '0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < UNITS; k++) check(par[k] == '0, "R8", "after reset", par[k], '0);

    foreach (m_list[i]) begin
      m_cfg = 6'(m_list[i]);
      idle(3);
      for (int f = 0; f < 5; f++) send_frame({$urandom, $urandom});
      idle(m_list[i] + 4);
      if (m_list[i] == 7) begin
        en = 1'b0;
        @(negedge clk);
        for (int k = 0; k < UNITS; k++) check(par[k] == '0, "R7", "disabled", par[k], '0);
        last_w = {$urandom, $urandom};
        send_frame(last_w);
        idle(m_list[i] + 4);
        en = 1'b1;
        @(negedge clk);
        check(par[0] == unit_exp(last_w, 7, 0), "R7", "word captured while disabled",
              par[0], unit_exp(last_w, 7, 0));
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule